// File: doc/BRIEF.md
# Parallel NOR Flash Reset and Power-Up Sequencer

This block sits in the host controller next to a parallel NOR flash. It owns the flash reset line and decides when the host may assert chip-enable and start bus cycles. It holds reset low for a programmable minimum time. This happens after power becomes good, and again whenever software asks for a reset. Chip-enable stays gated off until reset has been released. After release, a recovery timer must expire before the host is told that accesses may begin.

Reset is released only when the flash ready/busy line has been high without a break for a hold window. This covers the case where an embedded operation or a temporary-unprotect session is still running when reset is requested. The hold window applies after the minimum low time as well. All timing figures are given in nanoseconds. They are turned into clock cycles when the block is built, rounding up.

Top module: `flash_rst_seq`

## Requirements
- R1: Each duration is `ceil(ns * CLK_HZ / 1e9)` clock cycles. With a 4 ns clock, 201 ns gives 51 cycles, 120 ns gives 30 cycles and 37 ns gives 10 cycles.
- R2: While `pwr_good` is 0, `flash_rst_n`, `ce_allow` and `access_ok` are all 0, without waiting for a clock edge.
- R3: After `pwr_good` rises, or after the last cycle in which `rst_req` was 1, `flash_rst_n` stays 0 for at least the reset-low time (at most 5 cycles more when the ready line is high).
- R4: `rst_req` = 1 in any state drives `flash_rst_n` to 0 at the next clock edge and restarts the reset-low time from that edge.
- R5: `flash_rst_n` rises only after `flash_ready` has been 1 for at least the hold time without a break. The line passes through a two-stage synchronizer, so a release lands within 5 cycles of max(low time, busy time + hold time).
- R6: `ce_allow` is 0 whenever `flash_rst_n` is 0, and it rises in the same cycle as `flash_rst_n`.
- R7: `access_ok` is 0 while reset is low and throughout the recovery time. It rises 30 to 32 cycles after reset release with the bench settings, that is, recovery time plus at most 2 cycles.
- R8: `flash_ready` going low after reset release has no effect on `flash_rst_n`, `ce_allow`, `access_ok` or on the length of the recovery time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| pwr_good | input | 1 | Supply good; 0 clears the block asynchronously |
| rst_req | input | 1 | Software reset request, sampled each cycle |
| flash_ready | input | 1 | Flash ready/busy line, 1 = ready, asynchronous |
| flash_rst_n | output | 1 | Active-low reset to the flash |
| ce_allow | output | 1 | 1 = host may drive chip-enable low |
| access_ok | output | 1 | 1 = reset recovery complete, bus accesses allowed |

## Verification
Any wrong internal state in this block shows at the three outputs. A low-time or hold timer that expires early shows up as a release cycle earlier than the busy-dependent minimum. A stuck or skipped state shows up as `ce_allow` or `access_ok` high while reset is still low, or as no release at all. The bench measures release and recovery lengths for several busy times and checks each within a few cycles of its computed value. It also checks that a request in any state is reflected at the next edge and that a power loss clears the outputs at once.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RECOV = 2'd1,
    ST_READY = 2'd2
  } fseq_state_e;

  // nanoseconds to clock cycles, rounded up (R1)
  function automatic int ns2cyc(input longint ns, input longint hz);
    longint prod;
    prod = ns * hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int bits_for(input int val);
    return (val < 2) ? 1 : $clog2(val + 1);
  endfunction

endpackage

// File: rtl/fseq_sync.sv
module fseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int VAL = 8,
  parameter int W   = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic load,
  input  logic en,
  output logic done
);
  localparam logic [W-1:0] START = W'(VAL);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                 cnt <= START;
    else if (load)               cnt <= START;
    else if (en && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
  parameter longint CLK_HZ       = 250_000_000,
  parameter longint T_RST_LOW_NS = 35_000,
  parameter longint T_RECOVER_NS = 35_000,
  parameter longint T_HOLD_NS    = 4_000
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic rst_req,
  input  logic flash_ready,
  output logic flash_rst_n,
  output logic ce_allow,
  output logic access_ok
);
  import fseq_pkg::*;

  localparam int LOW_CYC  = ns2cyc(T_RST_LOW_NS, CLK_HZ);
  localparam int REC_CYC  = ns2cyc(T_RECOVER_NS, CLK_HZ);
  localparam int HOLD_CYC = ns2cyc(T_HOLD_NS, CLK_HZ);
  localparam int LOW_W    = bits_for(LOW_CYC);
  localparam int REC_W    = bits_for(REC_CYC);
  localparam int HOLD_W   = bits_for(HOLD_CYC);

  fseq_state_e state, state_nx;

  // named internal events, used by the checker
  logic ready_s;
  logic low_done;
  logic hold_met;
  logic rec_done;
  logic release_ev;

  fseq_sync #(.STAGES(2)) u_rdy_sync (
    .clk(clk), .arst_n(pwr_good), .d(flash_ready), .q(ready_s)
  );

  // minimum reset-low window, restarted by every request
  fseq_timer #(.VAL(LOW_CYC), .W(LOW_W)) u_low_tmr (
    .clk(clk), .arst_n(pwr_good),
    .load(rst_req), .en(state == ST_HOLD), .done(low_done)
  );

  // ready must stay high for the hold window without a break
  fseq_timer #(.VAL(HOLD_CYC), .W(HOLD_W)) u_hold_tmr (
    .clk(clk), .arst_n(pwr_good),
    .load(!ready_s), .en(1'b1), .done(hold_met)
  );

  // recovery after release, kept full while reset is low
  fseq_timer #(.VAL(REC_CYC), .W(REC_W)) u_rec_tmr (
    .clk(clk), .arst_n(pwr_good),
    .load(state == ST_HOLD), .en(state == ST_RECOV), .done(rec_done)
  );

  assign release_ev = (state == ST_HOLD) && low_done && hold_met && !rst_req;

  always_comb begin
    state_nx = state;
    if (rst_req) begin
      state_nx = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD:  if (release_ev) state_nx = ST_RECOV;
        ST_RECOV: if (rec_done)   state_nx = ST_READY;
        ST_READY: state_nx = ST_READY;
        default:  state_nx = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) state <= ST_HOLD;
    else           state <= state_nx;
  end

  assign flash_rst_n = (state != ST_HOLD);
  assign ce_allow    = (state != ST_HOLD);
  assign access_ok   = (state == ST_READY);

endmodule

// File: rtl/flash_rst_seq_chk.sv
module flash_rst_seq_chk (
  input logic clk,
  input logic pwr_good,
  input logic rst_req,
  input logic flash_rst_n,
  input logic ce_allow,
  input logic access_ok,
  input logic low_done,
  input logic hold_met,
  input logic rec_done
);
  a_r6_ce_off_in_reset: assert property (@(posedge clk) disable iff (!pwr_good)
    !flash_rst_n |-> !ce_allow);

  a_r7_access_after_release: assert property (@(posedge clk) disable iff (!pwr_good)
    access_ok |-> (flash_rst_n && ce_allow));

  a_r4_req_forces_low: assert property (@(posedge clk) disable iff (!pwr_good)
    rst_req |=> !flash_rst_n);

  a_r3_release_after_low: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(flash_rst_n) |-> $past(low_done));

  a_r5_release_after_hold: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(flash_rst_n) |-> $past(hold_met));

  a_r7_access_after_recovery: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(access_ok) |-> $past(rec_done));
endmodule

bind flash_rst_seq flash_rst_seq_chk u_chk (
  .clk(clk), .pwr_good(pwr_good), .rst_req(rst_req),
  .flash_rst_n(flash_rst_n), .ce_allow(ce_allow), .access_ok(access_ok),
  .low_done(low_done), .hold_met(hold_met), .rec_done(rec_done)
);

// File: tb/flash_rst_seq_bench.sv
`timescale 1ns/1ps
module flash_rst_seq_bench;
  // 4 ns clock; expected cycle counts: ns/4 rounded up (R1)
  function automatic int to_cyc(input int ns);
    return ns / 4 + ((ns % 4) != 0 ? 1 : 0);
  endfunction

  localparam int LOW_NS = 201, REC_NS = 120, HOLD_NS = 37;
  localparam int E_LOW = to_cyc(LOW_NS);
  localparam int E_REC = to_cyc(REC_NS);
  localparam int E_HOLD = to_cyc(HOLD_NS);
  localparam int NV = 4;
  localparam int BUSY_TAB [NV] = '{0, 30, 45, 70};

  logic clk = 1'b0;
  logic pwr_good = 1'b0, rst_req = 1'b0, flash_ready = 1'b1;
  logic flash_rst_n, ce_allow, access_ok;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_rst_seq #(.CLK_HZ(250_000_000), .T_RST_LOW_NS(LOW_NS),
                  .T_RECOVER_NS(REC_NS), .T_HOLD_NS(HOLD_NS)) u_flash_rst_seq (
    .clk(clk), .pwr_good(pwr_good), .rst_req(rst_req), .flash_ready(flash_ready),
    .flash_rst_n(flash_rst_n), .ce_allow(ce_allow), .access_ok(access_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts reset-low cycles then recovery cycles; ready raised after busy cycles
  task automatic run_seq(input int busy, output int lo, output int rec, output int ce_bad);
    lo = 0; rec = 0; ce_bad = 0;
    while (!flash_rst_n && lo < 5000) begin
      lo++;
      if (ce_allow || access_ok) ce_bad++;
      if (lo >= busy) flash_ready = 1'b1;
      @(negedge clk);
    end
    flash_ready = 1'b1;
    while (!access_ok && rec < 5000) begin
      rec++;
      if (!ce_allow) ce_bad++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_req(input bit busy_low);
    @(negedge clk);
    rst_req = 1'b1;
    if (busy_low) flash_ready = 1'b0;
    @(negedge clk);
    rst_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lo, rec, cb, expl;
    // R2: reset state while power is not good
    repeat (3) @(negedge clk);
    check(flash_rst_n == 1'b0, "R2 rst_n in power-off", flash_rst_n, 0);
    check(ce_allow == 1'b0, "R2 ce_allow in power-off", ce_allow, 0);
    check(access_ok == 1'b0, "R2 access_ok in power-off", access_ok, 0);

    // power-up: R1 R3 R6 R7
    pwr_good = 1'b1;
    @(negedge clk);
    run_seq(0, lo, rec, cb);
    check(lo >= E_LOW && lo <= E_LOW + 5, "R1 R3 power-up low time", lo, E_LOW);
    check(rec >= E_REC && rec <= E_REC + 2, "R7 power-up recovery", rec, E_REC);
    check(cb == 0, "R6 ce/access gating at power-up", cb, 0);

    // table: request with ready held busy for a varying time (R3 R4 R5 R7)
    for (int i = 0; i < NV; i++) begin
      pulse_req(BUSY_TAB[i] != 0);
      check(flash_rst_n == 1'b0, "R4 request drives reset low", flash_rst_n, 0);
      run_seq(BUSY_TAB[i], lo, rec, cb);
      expl = (BUSY_TAB[i] + E_HOLD > E_LOW) ? BUSY_TAB[i] + E_HOLD : E_LOW;
      check(lo >= expl && lo <= expl + 5, "R5 R3 low time vs busy", lo, expl);
      check(rec >= E_REC && rec <= E_REC + 2, "R7 recovery after request", rec, E_REC);
      check(cb == 0, "R6 gating during sequence", cb, 0);
    end

    // R4: request in the middle of reset-low restarts the window
    pulse_req(1'b0);
    repeat (20) @(negedge clk);
    pulse_req(1'b0);
    run_seq(0, lo, rec, cb);
    check(lo >= E_LOW && lo <= E_LOW + 5, "R4 restart in hold", lo, E_LOW);

    // R4 R7: request during recovery
    pulse_req(1'b0);
    while (!flash_rst_n) @(negedge clk);
    repeat (5) @(negedge clk);
    pulse_req(1'b0);
    check(flash_rst_n == 1'b0 && access_ok == 1'b0, "R4 request in recovery",
          {flash_rst_n, access_ok}, 0);
    run_seq(0, lo, rec, cb);

    // R8: ready low after release has no effect
    flash_ready = 1'b0;
    repeat (20) @(negedge clk);
    check(flash_rst_n && ce_allow && access_ok, "R8 ready low in ready state",
          {flash_rst_n, ce_allow, access_ok}, 7);
    flash_ready = 1'b1;
    pulse_req(1'b0);
    while (!flash_rst_n) @(negedge clk);
    flash_ready = 1'b0;
    rec = 0;
    while (!access_ok && rec < 5000) begin rec++; @(negedge clk); end
    check(rec >= E_REC - 1 && rec <= E_REC + 2, "R8 recovery unaffected by ready", rec, E_REC);
    flash_ready = 1'b1;

    // R2: power loss clears outputs at once
    @(negedge clk);
    #1 pwr_good = 1'b0;
    #0.5;
    check({flash_rst_n, ce_allow, access_ok} == 3'b000, "R2 async power loss",
          {flash_rst_n, ce_allow, access_ok}, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule